// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block serves the transmit side of a network controller. The host software builds a ring of descriptors in a buffer memory that it shares with the block. Each descriptor names a data buffer and carries control flags. A kick request starts a scan of the ring, provided the transmitter is enabled. The engine then reads each descriptor it owns, checks it, and reads the buffer it points to. The buffer bytes leave the block as a byte stream, with markers on the first and last byte of each frame. The engine then returns the descriptor to the host by clearing its ownership flag in memory.

One frame may span several buffers. A start flag opens the frame and an end flag closes it, and each descriptor that completes a frame raises a one-cycle done pulse. The scan stops at the first entry the engine does not own or whose marker is wrong, and it stops with an error pulse at an entry that is malformed. The scan also ends when the ring index comes all the way back to the entry where the scan began. The ring index is kept from one scan to the next, so each scan resumes where the last one stopped.

The memory port is 16 bits wide with a byte address. It uses a request/grant handshake with one access in flight at a time.

Top module: `txring_engine`

## Requirements
- R1: After reset, `busy`, `mem_req`, `out_valid`, `tx_done`, `scan_err` and `frame_abort` are all low, and the ring index is 0.
- R2: A `tx_kick` pulse while idle and enabled raises `mem_req` in the cycle after the kick's clock edge, as a read of ring_base + 8*index + 2. A kick taken while `tx_enable` is low is remembered, and its scan starts in the cycle after `tx_enable` goes high.
- R3: An entry whose word 1 has bit 15 (ownership) clear ends the scan. It produces no bytes, no memory write and no error.
- R4: An entry whose word 2 bits 15:12 are not 4'hF ends the scan. It produces no bytes, no memory write and no error.
- R5: The byte count is 4096 minus word 2 bits 11:0. A count below 12 or above 1900 gives a one-cycle `scan_err` and ends the scan, and the entry is not written. Counts of 12 and 1900 are accepted.
- R6: The buffer address is word 1 bits 7:0 joined above word 0. The bytes are sent in ascending address order, one per `out_valid` cycle. An even byte address takes the low half of its 16-bit word and an odd address takes the high half.
- R7: Word 1 bit 9 (start) puts `out_sop` on the first byte of the entry. Word 1 bit 8 (end) puts `out_eop` and `tx_done` on the last byte. Entries that carry neither flag add their bytes to the open frame with no markers.
- R8: An entry without the start flag, reached while no frame is open, gives `scan_err` and ends the scan with no bytes sent.
- R9: An entry with the start flag, reached while a frame is open, pulses `frame_abort` before its first byte and then begins a new frame.
- R10: A consumed entry has word 1 written back with bit 15 cleared and its other bits unchanged. Words 2 and 3 are written back unchanged.
- R11: After each consumed entry, the index advances modulo 2^`ring_size_code`. The scan ends when the next index equals the index at which the scan started.
- R12: Once raised, `mem_req` stays high with a stable address and direction until the cycle in which `mem_grant` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_enable | input | 1 | Transmitter enabled |
| tx_kick | input | 1 | Transmit demand / poll pulse |
| ring_base | input | 24 | Byte address of descriptor 0 (8-byte aligned) |
| ring_size_code | input | 3 | Ring holds 2^code entries |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 24 | Byte address, word aligned |
| mem_wdata | output | 16 | Write data |
| mem_grant | input | 1 | Access completes this cycle |
| mem_rdata | input | 16 | Read data, valid with grant |
| out_valid | output | 1 | Byte valid |
| out_byte | output | 8 | Frame byte |
| out_sop | output | 1 | First byte of a frame |
| out_eop | output | 1 | Last byte of a frame |
| frame_abort | output | 1 | Open frame dropped |
| tx_done | output | 1 | Frame completed |
| scan_err | output | 1 | Malformed entry, scan halted |
| busy | output | 1 | Scan in progress |

## Verification
After a kick, the first descriptor read is due on `mem_req` in the very next cycle. The bench checks this at the falling edge straight after the kick's clock edge, and checks one cycle later that the address has held while the grant is pending. The bench memory grants each request one cycle after it is raised, so every access takes two cycles. Byte, marker, done, abort and error outputs are registered and last one cycle. A monitor on the falling edge therefore captures each of them once, and the bench compares the captured streams and the memory contents only after `busy` has dropped and three more cycles have passed.

// File: rtl/txr_pkg.sv
// Shared types and constants of the transmit descriptor ring engine.
// Assumes a 16-bit little-endian shared memory word.
package txr_pkg;
    localparam int WORD_W   = 16;
    localparam int OWN_BIT  = 15;
    localparam int STP_BIT  = 9;
    localparam int ENP_BIT  = 8;
    localparam logic [3:0] MARK_NIB = 4'hF;

    typedef enum logic [3:0] {
        S_IDLE, S_RD1, S_RD2, S_RD0, S_RD3, S_CHK,
        S_FETCH, S_EMIT, S_WB1, S_WB2, S_WB3, S_NEXT
    } txr_state_e;

    typedef struct packed {
        logic        own;
        logic        stp;
        logic        enp;
        logic        mark_ok;
        logic        len_ok;
        logic [12:0] len;
    } txr_desc_t;
endpackage

// File: rtl/txr_desc_decode.sv
// Descriptor field decoder: turns the flag bits and the count word into
// flags, a byte length and validity bits. Purely combinational.
module txr_desc_decode
    import txr_pkg::*;
#(
    parameter int FW      = 12,
    parameter int LEN_MIN = 12,
    parameter int LEN_MAX = 1900
) (
    input  logic              own_bit,
    input  logic              stp_bit,
    input  logic              enp_bit,
    input  logic [WORD_W-1:0] cnt_word,
    output txr_desc_t         desc
);
    localparam int LW = FW + 1;
    localparam logic [LW-1:0] SPAN = LW'(1) << FW;

    logic [LW-1:0] len;

    // Length from the negated count field
    always_comb begin
        len          = SPAN - {1'b0, cnt_word[FW-1:0]};
        desc.own     = own_bit;
        desc.stp     = stp_bit;
        desc.enp     = enp_bit;
        desc.mark_ok = (cnt_word[WORD_W-1:FW] == MARK_NIB);
        desc.len_ok  = (len >= LW'(LEN_MIN)) && (len <= LW'(LEN_MAX));
        desc.len     = 13'(len);
    end
endmodule

// File: rtl/txr_ring_ptr.sv
// Ring index keeper: holds the current entry index, wraps it at the ring
// size and remembers the index where the current scan began.
module txr_ring_ptr #(
    parameter int CODEW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CODEW-1:0] size_code,
    input  logic             mark_start,
    input  logic             advance,
    output logic [(2**CODEW)-2:0] idx,
    output logic             next_is_start
);
    localparam int IDXW = (2**CODEW) - 1;

    logic [IDXW-1:0] idx_q, start_q, mask, nxt;
    logic [IDXW:0]   span;

    // Mask and successor derived from the size code
    always_comb begin
        span          = (IDXW+1)'(1) << size_code;
        mask          = IDXW'(span - 1'b1);
        idx           = idx_q & mask;
        nxt           = (idx + 1'b1) & mask;
        next_is_start = (nxt == start_q);
    end

    // Index and scan-start registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            start_q <= '0;
        end else begin
            if (mark_start) start_q <= idx;
            if (advance)    idx_q   <= nxt;
        end
    end
endmodule

// File: rtl/txr_byte_gather.sv
// Buffer byte walker: holds the byte pointer, remaining count and the last
// fetched memory word, and selects the byte for the current address.
module txr_byte_gather
    import txr_pkg::*;
#(
    parameter int AW = 24,
    parameter int LW = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [AW-1:0]     load_addr,
    input  logic [LW-1:0]     load_len,
    input  logic              word_we,
    input  logic [WORD_W-1:0] word_in,
    input  logic              step,
    output logic [AW-1:0]     fetch_addr,
    output logic [7:0]        cur_byte,
    output logic              last,
    output logic              refetch
);
    logic [AW-1:0]     ptr_q;
    logic [LW-1:0]     remain_q;
    logic [WORD_W-1:0] word_q;

    // Byte selection and walk status
    always_comb begin
        fetch_addr = {ptr_q[AW-1:1], 1'b0};
        cur_byte   = ptr_q[0] ? word_q[15:8] : word_q[7:0];
        last       = (remain_q == LW'(1));
        refetch    = ptr_q[0];
    end

    // Pointer, count and word registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            remain_q <= '0;
            word_q   <= '0;
        end else begin
            if (load) begin
                ptr_q    <= load_addr;
                remain_q <= load_len;
            end else if (step) begin
                ptr_q    <= ptr_q + 1'b1;
                remain_q <= remain_q - 1'b1;
            end
            if (word_we) word_q <= word_in;
        end
    end
endmodule

// File: rtl/txring_engine.sv
// Transmit descriptor ring engine. It scans owned descriptors, streams
// their buffer bytes with frame markers and returns ownership to the host.
// Assumes ring_base is 8-byte aligned and at most one memory access in flight.
module txring_engine
    import txr_pkg::*;
#(
    parameter int AW      = 24,
    parameter int FW      = 12,
    parameter int LEN_MIN = 12,
    parameter int LEN_MAX = 1900,
    parameter int CODEW   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic              tx_kick,
    input  logic [AW-1:0]     ring_base,
    input  logic [CODEW-1:0]  ring_size_code,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_grant,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              out_sop,
    output logic              out_eop,
    output logic              frame_abort,
    output logic              tx_done,
    output logic              scan_err,
    output logic              busy
);
    localparam int LW   = FW + 1;
    localparam int IDXW = (2**CODEW) - 1;

    txr_state_e        state;
    logic              pend_q, open_q, sop_pend;
    logic [WORD_W-1:0] w0_q, w1_q, w2_q, w3_q;
    txr_desc_t         dsc;
    logic [IDXW-1:0]   idx;
    logic              at_start, p_mark, p_adv, acc, go;
    logic              g_load, g_last, g_refetch;
    logic [AW-1:0]     g_faddr, desc_base;
    logic [7:0]        g_byte;

    txr_desc_decode #(.FW(FW), .LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX)) u_dec (
        .own_bit (w1_q[OWN_BIT]),
        .stp_bit (w1_q[STP_BIT]),
        .enp_bit (w1_q[ENP_BIT]),
        .cnt_word(w2_q),
        .desc    (dsc)
    );

    txr_ring_ptr #(.CODEW(CODEW)) u_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .size_code    (ring_size_code),
        .mark_start   (p_mark),
        .advance      (p_adv),
        .idx          (idx),
        .next_is_start(at_start)
    );

    txr_byte_gather #(.AW(AW), .LW(LW)) u_gat (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (g_load),
        .load_addr ({w1_q[7:0], w0_q}),
        .load_len  (dsc.len),
        .word_we   (state == S_FETCH && acc),
        .word_in   (mem_rdata),
        .step      (state == S_EMIT),
        .fetch_addr(g_faddr),
        .cur_byte  (g_byte),
        .last      (g_last),
        .refetch   (g_refetch)
    );

    // Scan start, ring advance and buffer load strobes
    always_comb begin
        go     = tx_enable && (pend_q || tx_kick);
        p_mark = (state == S_IDLE) && go;
        p_adv  = (state == S_NEXT);
        g_load = (state == S_CHK) && dsc.own && dsc.mark_ok && dsc.len_ok
                 && (dsc.stp || open_q);
        busy   = (state != S_IDLE);
    end

    // Memory port: address, direction and write data per state
    always_comb begin
        desc_base = ring_base + AW'({idx, 3'b000});
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_base;
        mem_wdata = '0;
        unique case (state)
            S_RD0:   begin mem_req = 1'b1; end
            S_RD1:   begin mem_req = 1'b1; mem_addr = desc_base + AW'(2); end
            S_RD2:   begin mem_req = 1'b1; mem_addr = desc_base + AW'(4); end
            S_RD3:   begin mem_req = 1'b1; mem_addr = desc_base + AW'(6); end
            S_FETCH: begin mem_req = 1'b1; mem_addr = g_faddr; end
            S_WB1: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr  = desc_base + AW'(2);
                mem_wdata = w1_q & ~(WORD_W'(1) << OWN_BIT);
            end
            S_WB2: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = desc_base + AW'(4); mem_wdata = w2_q;
            end
            S_WB3: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = desc_base + AW'(6); mem_wdata = w3_q;
            end
            default: ;
        endcase
        acc = mem_req && mem_grant;
    end

    // Scan sequencer with registered stream and event outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            pend_q      <= 1'b0;
            open_q      <= 1'b0;
            sop_pend    <= 1'b0;
            w0_q        <= '0;
            w1_q        <= '0;
            w2_q        <= '0;
            w3_q        <= '0;
            out_valid   <= 1'b0;
            out_byte    <= '0;
            out_sop     <= 1'b0;
            out_eop     <= 1'b0;
            frame_abort <= 1'b0;
            tx_done     <= 1'b0;
            scan_err    <= 1'b0;
        end else begin
            out_valid   <= 1'b0;
            out_sop     <= 1'b0;
            out_eop     <= 1'b0;
            frame_abort <= 1'b0;
            tx_done     <= 1'b0;
            scan_err    <= 1'b0;
            if (tx_kick) pend_q <= 1'b1;
            unique case (state)
                S_IDLE: if (go) begin
                    pend_q <= 1'b0;
                    state  <= S_RD1;
                end
                S_RD1: if (acc) begin w1_q <= mem_rdata; state <= S_RD2; end
                S_RD2: if (acc) begin w2_q <= mem_rdata; state <= S_RD0; end
                S_RD0: if (acc) begin w0_q <= mem_rdata; state <= S_RD3; end
                S_RD3: if (acc) begin w3_q <= mem_rdata; state <= S_CHK; end
                S_CHK: begin
                    if (!dsc.own || !dsc.mark_ok) begin
                        state <= S_IDLE;
                    end else if (!dsc.len_ok || (!dsc.stp && !open_q)) begin
                        scan_err <= 1'b1;
                        state    <= S_IDLE;
                    end else begin
                        if (dsc.stp && open_q) frame_abort <= 1'b1;
                        sop_pend <= dsc.stp;
                        state    <= S_FETCH;
                    end
                end
                S_FETCH: if (acc) state <= S_EMIT;
                S_EMIT: begin
                    out_valid <= 1'b1;
                    out_byte  <= g_byte;
                    out_sop   <= sop_pend;
                    out_eop   <= g_last && dsc.enp;
                    sop_pend  <= 1'b0;
                    if (g_last) begin
                        if (dsc.enp) begin
                            tx_done <= 1'b1;
                            open_q  <= 1'b0;
                        end else begin
                            open_q  <= 1'b1;
                        end
                        state <= S_WB1;
                    end else if (g_refetch) begin
                        state <= S_FETCH;
                    end
                end
                S_WB1: if (acc) state <= S_WB2;
                S_WB2: if (acc) state <= S_WB3;
                S_WB3: if (acc) state <= S_NEXT;
                S_NEXT: state <= at_start ? S_IDLE : S_RD1;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txr_chk.sv
// Protocol checker for the transmit descriptor ring engine, bound to the top.
module txr_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_enable,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_grant,
    input logic          wdata_top,
    input logic          out_valid,
    input logic          out_sop,
    input logic          out_eop,
    input logic          tx_done,
    input logic          scan_err,
    input logic          busy
);
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_grant |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R10
    own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && (mem_addr[2:0] == 3'b010) |-> !wdata_top);

    // R7
    done_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> out_valid && out_eop);

    // R7
    marker_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !tx_enable |=> !busy);

    // R5
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_err |-> !busy && !out_valid);
endmodule

bind txring_engine txr_chk #(.AW(AW)) u_txr_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_enable(tx_enable),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_grant(mem_grant),
    .wdata_top(mem_wdata[15]),
    .out_valid(out_valid),
    .out_sop  (out_sop),
    .out_eop  (out_eop),
    .tx_done  (tx_done),
    .scan_err (scan_err),
    .busy     (busy)
);

// File: tb/txring_engine_tb_top.sv
// Self-checking bench for txring_engine with a shared-memory model.
module txring_engine_tb_top;
    localparam logic [23:0] RING = 24'h000100;

    typedef struct packed {
        logic [12:0] len;
        logic [3:0]  mark;
        logic        own, stp, enp, odd;
        logic [12:0] exp_n;
        logic        exp_err, exp_done;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{13'd12,   4'hF, 1'b1, 1'b1, 1'b1, 1'b0, 13'd12,   1'b0, 1'b1},
        '{13'd1900, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0, 13'd1900, 1'b0, 1'b1},
        '{13'd11,   4'hF, 1'b1, 1'b1, 1'b1, 1'b0, 13'd0,    1'b1, 1'b0},
        '{13'd1901, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0, 13'd0,    1'b1, 1'b0},
        '{13'd12,   4'hF, 1'b0, 1'b1, 1'b1, 1'b0, 13'd0,    1'b0, 1'b0},
        '{13'd12,   4'hE, 1'b1, 1'b1, 1'b1, 1'b0, 13'd0,    1'b0, 1'b0},
        '{13'd12,   4'hF, 1'b1, 1'b0, 1'b1, 1'b0, 13'd0,    1'b1, 1'b0},
        '{13'd13,   4'hF, 1'b1, 1'b1, 1'b1, 1'b1, 13'd13,   1'b0, 1'b1}
    };

    logic        clk = 1'b0, rst_n = 1'b0, tx_enable = 1'b1, tx_kick = 1'b0;
    logic [2:0]  size_code = 3'd0;
    logic        mem_req, mem_we, mem_grant, out_valid, out_sop, out_eop;
    logic        frame_abort, tx_done, scan_err, busy;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [7:0]  out_byte;

    logic [15:0] mem [0:4095];
    logic        pk_en = 1'b0;
    logic [11:0] pk_addr = '0;
    logic [15:0] pk_data = '0;
    int          wr_cnt, rd1_cnt;

    logic [7:0]  cap_b [0:2047];
    logic        cap_s [0:2047];
    logic        cap_e [0:2047];
    int          ncap, ndone, nabort, nerrp;
    int          nchk = 0, nerr = 0;

    always #5 clk = ~clk;

    txring_engine dut_i (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .tx_kick(tx_kick),
        .ring_base(RING), .ring_size_code(size_code),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_grant(mem_grant), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_byte(out_byte), .out_sop(out_sop),
        .out_eop(out_eop), .frame_abort(frame_abort), .tx_done(tx_done),
        .scan_err(scan_err), .busy(busy)
    );

    function automatic logic [7:0] pat(input logic [23:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    // Memory model: grants each request one cycle after it is raised
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_grant <= 1'b0;
            mem_rdata <= '0;
            wr_cnt    <= 0;
            rd1_cnt   <= 0;
            for (int i = 0; i < 4096; i++)
                mem[i] <= {pat(24'(2*i+1)), pat(24'(2*i))};
        end else begin
            mem_grant <= mem_req && !mem_grant;
            if (mem_req && !mem_grant) begin
                mem_rdata <= mem[mem_addr[12:1]];
                if (mem_we) begin
                    mem[mem_addr[12:1]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else if (mem_addr[2:0] == 3'b010 && mem_addr >= RING
                             && mem_addr < RING + 24'h40) begin
                    rd1_cnt <= rd1_cnt + 1;
                end
            end
            if (pk_en) mem[pk_addr] <= pk_data;
        end
    end

    // Output monitor on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && ncap < 2048) begin
                cap_b[ncap] = out_byte;
                cap_s[ncap] = out_sop;
                cap_e[ncap] = out_eop;
                ncap = ncap + 1;
            end
            if (tx_done)     ndone  = ndone + 1;
            if (frame_abort) nabort = nabort + 1;
            if (scan_err)    nerrp  = nerrp + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        pk_en = 1'b1; pk_addr = a[12:1]; pk_data = d;
        @(negedge clk);
        pk_en = 1'b0;
    endtask

    task automatic put_desc(input int idx, input logic [23:0] buf_a, input int len,
                            input logic own, input logic stp, input logic enp,
                            input logic [3:0] mark);
        logic [11:0] fld;
        fld = 12'(4096 - len);
        poke(RING + 24'(8*idx),     buf_a[15:0]);
        poke(RING + 24'(8*idx + 2), {own, 5'b0, stp, enp, buf_a[23:16]});
        poke(RING + 24'(8*idx + 4), {mark, fld});
        poke(RING + 24'(8*idx + 6), 16'hC0DE);
    endtask

    task automatic clr_caps();
        ncap = 0; ndone = 0; nabort = 0; nerrp = 0;
    endtask

    task automatic run_scan();
        @(negedge clk) tx_kick = 1'b1;
        @(negedge clk) tx_kick = 1'b0;
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic string tag_of(input int v);
        case (v)
            0, 7:    return "R6";
            1, 2, 3: return "R5";
            4:       return "R3";
            5:       return "R4";
            default: return "R8";
        endcase
    endfunction

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [15:0] w1e;
        int bad, wr0;
        clr_caps();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 out_valid", out_valid | tx_done | scan_err | frame_abort, 0);

        // Table of single-entry cases on a one-entry ring
        for (int v = 0; v < 8; v++) begin
            automatic vec_t t = VEC[v];
            automatic logic [23:0] ba = 24'h400 + 24'(t.odd);
            put_desc(0, ba, int'(t.len), t.own, t.stp, t.enp, t.mark);
            w1e = mem[(RING + 24'd2) >> 1];
            clr_caps(); wr0 = wr_cnt;
            run_scan();
            chk({tag_of(v), " byte count"}, ncap, 32'(t.exp_n));
            chk({tag_of(v), " error pulses"}, nerrp, 32'(t.exp_err));
            chk("R7 done pulses", ndone, 32'(t.exp_done));
            chk("R10 word1 writeback", mem[(RING + 24'd2) >> 1],
                t.exp_done ? (w1e & 16'h7FFF) : w1e);
            chk({tag_of(v), " writes"}, wr_cnt - wr0, t.exp_done ? 3 : 0);
            bad = 0;
            for (int i = 0; i < ncap; i++)
                if (cap_b[i] !== pat(ba + 24'(i))) bad++;
            chk("R6 byte values", bad, 0);
            if (t.exp_n != 0) begin
                chk("R7 sop first", cap_s[0], 1);
                chk("R7 eop last", cap_e[ncap-1], 1);
            end
        end

        // R2: request timing and held address (R12)
        put_desc(0, 24'h600, 12, 1, 1, 1, 4'hF);
        clr_caps();
        @(negedge clk) tx_kick = 1'b1;
        @(negedge clk) tx_kick = 1'b0;
        chk("R2 req after kick", mem_req, 1);
        chk("R2 first address", mem_addr, RING + 24'd2);
        chk("R12 grant pending", mem_grant, 0);
        @(negedge clk);
        chk("R12 address held", mem_addr, RING + 24'd2);
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R2 scan bytes", ncap, 12);

        // R2: kick while disabled is remembered
        put_desc(0, 24'h600, 12, 1, 1, 1, 4'hF);
        clr_caps();
        tx_enable = 1'b0;
        run_scan();
        chk("R2 disabled stays idle", busy | ncap[0] | 32'(ncap != 0), 0);
        @(negedge clk) tx_enable = 1'b1;
        @(negedge clk);
        chk("R2 pending kick starts", busy, 1);
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R2 pending scan bytes", ncap, 12);

        // R7/R10: three-buffer frame on a four-entry ring
        size_code = 3'd2;
        put_desc(0, 24'h600, 20, 1, 1, 0, 4'hF);
        put_desc(1, 24'h701, 15, 1, 0, 0, 4'hF);
        put_desc(2, 24'h800, 12, 1, 0, 1, 4'hF);
        put_desc(3, 24'h900, 12, 0, 1, 1, 4'hF);
        clr_caps();
        run_scan();
        chk("R7 chained bytes", ncap, 47);
        chk("R7 one done", ndone, 1);
        bad = 0;
        for (int i = 0; i < 47; i++) begin
            automatic logic [23:0] a = (i < 20) ? 24'h600 + 24'(i) :
                                       (i < 35) ? 24'h701 + 24'(i-20) : 24'h800 + 24'(i-35);
            if (cap_b[i] !== pat(a)) bad++;
            if (cap_s[i] !== (i == 0)) bad++;
            if (cap_e[i] !== (i == 46)) bad++;
        end
        chk("R7 chained content and markers", bad, 0);
        chk("R10 mid entry word1", mem[(RING + 24'd10) >> 1], 16'h0000);
        chk("R10 word2 kept", mem[(RING + 24'd12) >> 1], {4'hF, 12'(4096 - 15)});
        chk("R10 word3 kept", mem[(RING + 24'd14) >> 1], 16'hC0DE);
        chk("R3 unowned untouched", mem[(RING + 24'd26) >> 1], 16'h0300);

        // R9: start flag while a frame is open, across the ring wrap (R11)
        put_desc(3, 24'h900, 12, 1, 1, 0, 4'hF);
        put_desc(0, 24'hA00, 12, 1, 1, 1, 4'hF);
        put_desc(1, 24'h600, 12, 0, 1, 1, 4'hF);
        clr_caps();
        run_scan();
        chk("R9 abort pulse", nabort, 1);
        chk("R9 bytes", ncap, 24);
        chk("R9 new sop", {cap_s[0], cap_s[12], cap_e[11], cap_e[23]}, 4'b1101);
        chk("R11 wrapped to entry 0", cap_b[12], pat(24'hA00));

        // R11: scan ends when it returns to its start index
        size_code = 3'd1;
        put_desc(0, 24'h600, 12, 1, 1, 1, 4'hF);
        put_desc(1, 24'h700, 12, 1, 1, 1, 4'hF);
        clr_caps(); wr0 = rd1_cnt;
        run_scan();
        chk("R11 entries visited", rd1_cnt - wr0, 2);
        chk("R11 frames", ndone, 2);
        chk("R11 starts at kept index", cap_b[0], pat(24'h700));

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule